// File: doc/BRIEF.md
# Block Write-Protect Address Filter

This block sits between the byte-address counter of a serial memory's write path and the array's write strobe. For every byte that the write path is about to commit, it decides whether that byte may reach the array. The address space is cut into sixteen equal blocks, indexed by the four most significant address bits. A protected region of zero to fifteen adjacent blocks is described by a start block and a block count. One separately named high-endurance block is never protected, even when it falls inside the region.

The decision is purely combinational on the present byte address. A page write therefore re-evaluates each byte as the address counter advances, so a burst that straddles a region edge commits the bytes outside the region and drops the bytes inside it. A dropped byte raises no error and does not end the command. The surrounding write sequence simply carries on, and the array sees no strobe for that byte.

The block holds no state. It is a range decoder that builds a sixteen-bit protection mask, an override stage that clears the high-endurance block from that mask, and a gate that selects the mask bit for the addressed block and qualifies the write request with it.

Top module: `wp_filter`

## Requirements
- R1: The block index of a byte is address bits [12:9], so each block spans 512 bytes; block k covers addresses k*512 through k*512+511.
- R2: `wr_en` is never high while `wr_req` is low.
- R3: When `blk_cnt` is 0, every block is writable, so `wr_en` equals `wr_req` for every address.
- R4: A byte whose block index b satisfies start <= b <= start+count-1 (and is not the high-endurance block) is protected: `wr_en` stays low while `wr_req` is high.
- R5: A byte whose block index is below `start_blk` is always writable.
- R6: The region is clipped at block 15 and never wraps, so with start 14 and count 5 only blocks 14 and 15 are protected, and blocks 0 and 1 stay writable.
- R7: The block equal to `he_blk` is always writable, wherever it lies relative to the region.
- R8: `wr_en` follows the current address with no delay. A sequence of byte addresses that crosses a region edge yields high enable on the unprotected bytes and low enable on the protected ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 13 | Byte address of the byte about to be written |
| wr_req | input | 1 | The write path wants to commit this byte |
| start_blk | input | 4 | First block of the protected region |
| blk_cnt | input | 4 | Number of protected blocks (0 to 15) |
| he_blk | input | 4 | Index of the high-endurance block, exempt from protection |
| wr_en | output | 1 | Array write strobe for this byte |

## Verification
The assertions take the configuration inputs to be stable and known whenever they are evaluated, with 4-bit values in their full 0 to 15 range. They also take the address and write request to be settled combinational values. Because the block is combinational, the immediate assertions sit inside the stages and assume nothing about ordering between bytes. The stimulus changes every input only just after a bench clock edge and samples half a period later, so each sample sees settled values. The stimulus sweeps all start and count pairs against every block, including counts that run past block 15 and high-endurance indexes both inside and outside the region.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int ADDR_W = 13;
    localparam int BLK_W  = 4;
    localparam int NBLK   = 1 << BLK_W;
endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
    parameter int BLK_W = wp_pkg::BLK_W,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic [BLK_W-1:0] start_blk,
    input  logic [BLK_W-1:0] blk_cnt,
    output logic [NBLK-1:0]  range_mask
);
    localparam int EW = BLK_W + 1;

    logic [EW-1:0] lo_ext;
    logic [EW-1:0] hi_ext;

    // Extended width: start+count may exceed the last block index, which
    // clips the region at the top instead of wrapping to block 0.
    assign lo_ext = {1'b0, start_blk};
    assign hi_ext = {1'b0, start_blk} + {1'b0, blk_cnt};

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        assign range_mask[i] = (EW'(i) >= lo_ext) && (EW'(i) < hi_ext);
    end

    always_comb begin
        // R3, R6: never more blocks marked than requested
        assert_mask_within_count_R6: assert ($countones(range_mask) <= int'(blk_cnt))
            else $error("range mask larger than count");
        // R3: empty region
        assert_zero_count_empty_R3: assert ((blk_cnt != '0) || (range_mask == '0))
            else $error("count zero but mask set");
        // R5: nothing below start
        assert_below_start_clear_R5: assert ((range_mask & ((NBLK'(1) << start_blk) - NBLK'(1))) == '0)
            else $error("block below start marked");
    end
endmodule

// File: rtl/wp_endurance_override.sv
module wp_endurance_override #(
    parameter int BLK_W = wp_pkg::BLK_W,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic [NBLK-1:0]  range_mask,
    input  logic [BLK_W-1:0] he_blk,
    output logic [NBLK-1:0]  prot_mask
);
    for (genvar i = 0; i < NBLK; i++) begin : g_ovr
        assign prot_mask[i] = range_mask[i] && (he_blk != BLK_W'(i));
    end

    always_comb begin
        // R7: exempt block never protected
        assert_he_exempt_R7: assert (prot_mask[he_blk] == 1'b0)
            else $error("high-endurance block protected");
        // R4: override only removes protection
        assert_override_subset_R4: assert ((prot_mask & ~range_mask) == '0)
            else $error("override added protection");
    end
endmodule

// File: rtl/wp_byte_gate.sv
module wp_byte_gate #(
    parameter int BLK_W = wp_pkg::BLK_W,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic [BLK_W-1:0] blk_idx,
    input  logic [NBLK-1:0]  prot_mask,
    input  logic             wr_req,
    output logic             wr_en
);
    logic blk_locked;

    assign blk_locked = prot_mask[blk_idx];
    assign wr_en      = wr_req && !blk_locked;

    always_comb begin
        // R2: no strobe without request
        assert_no_spurious_R2: assert (wr_req || !wr_en)
            else $error("write enable without request");
        // R4: request into unlocked block is granted
        assert_grant_unlocked_R4: assert (!(wr_req && (prot_mask == '0)) || wr_en)
            else $error("request dropped with empty mask");
    end
endmodule

// File: rtl/wp_filter.sv
module wp_filter #(
    parameter int ADDR_W = wp_pkg::ADDR_W,
    parameter int BLK_W  = wp_pkg::BLK_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_req,
    input  logic [BLK_W-1:0]  start_blk,
    input  logic [BLK_W-1:0]  blk_cnt,
    input  logic [BLK_W-1:0]  he_blk,
    output logic              wr_en
);
    localparam int NBLK = 1 << BLK_W;

    logic [BLK_W-1:0] blk_idx;
    logic [NBLK-1:0]  range_mask;
    logic [NBLK-1:0]  prot_mask;

    // R1: block index from the top address bits
    assign blk_idx = addr[ADDR_W-1 -: BLK_W];

    wp_range_decode #(.BLK_W(BLK_W)) u_range (
        .start_blk (start_blk),
        .blk_cnt   (blk_cnt),
        .range_mask(range_mask)
    );

    wp_endurance_override #(.BLK_W(BLK_W)) u_ovr (
        .range_mask(range_mask),
        .he_blk    (he_blk),
        .prot_mask (prot_mask)
    );

    wp_byte_gate #(.BLK_W(BLK_W)) u_gate (
        .blk_idx  (blk_idx),
        .prot_mask(prot_mask),
        .wr_req   (wr_req),
        .wr_en    (wr_en)
    );

    always_comb begin
        // R7: addressed exempt block passes the request through
        assert_he_passes_R7: assert (!(wr_req && (blk_idx == he_blk)) || wr_en)
            else $error("exempt block write dropped");
        // R3: zero count passes everything
        assert_zero_count_pass_R3: assert ((blk_cnt != '0) || (wr_en == wr_req))
            else $error("zero count gated a write");
    end
endmodule

// File: tb/wp_filter_bench.sv
module wp_filter_bench;
    localparam int PERIOD = 10;

    typedef struct {
        logic  exp;
        string rid;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        wr_req = 1'b0;
    logic [3:0]  start_blk = 4'd15;
    logic [3:0]  blk_cnt = 4'd0;
    logic [3:0]  he_blk = 4'd0;
    logic        wr_en;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    wp_filter u_wp_filter (
        .addr(addr), .wr_req(wr_req), .start_blk(start_blk),
        .blk_cnt(blk_cnt), .he_blk(he_blk), .wr_en(wr_en)
    );

    function automatic logic model(input int a, input logic req,
                                   input int st, input int cnt, input int he);
        int b;
        b = a / 512;
        if (!req) return 1'b0;
        if (b == he) return 1'b1;
        if (b >= st && b < st + cnt) return 1'b0;
        return 1'b1;
    endfunction

    task automatic drive(input int a, input logic req, input int st,
                         input int cnt, input int he, input string rid);
        item_t it;
        @(posedge clk);
        #1;
        addr = 13'(a); wr_req = req; start_blk = 4'(st);
        blk_cnt = 4'(cnt); he_blk = 4'(he);
        it.exp = model(a, req, st, cnt, he);
        it.rid = rid;
        sb.push_back(it);
    endtask

    // monitor: compares at the falling edge, half a period after driving
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (wr_en !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%h st=%0d cnt=%0d he=%0d: wr_en actual=%b expected=%b",
                         it.rid, addr, start_blk, blk_cnt, he_blk, wr_en, it.exp);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset-state defaults, no request: R2
        drive(0, 1'b0, 15, 0, 0, "R2");
        // R1: block boundary 511/512 with block 1 protected
        drive(511, 1'b1, 1, 1, 9, "R1");
        drive(512, 1'b1, 1, 1, 9, "R1");
        drive(1023, 1'b1, 1, 1, 9, "R1");
        drive(1024, 1'b1, 1, 1, 9, "R1");
        // R2: no request inside protected and free blocks
        drive(3000, 1'b0, 0, 15, 9, "R2");
        drive(8191, 1'b0, 0, 0, 0, "R2");
        // R3: zero count
        for (int b = 0; b < 16; b++) drive(b*512 + 7, 1'b1, 3, 0, 0, "R3");
        // R4: interior and last block of region
        drive(5*512, 1'b1, 4, 3, 0, "R4");
        drive(6*512 + 511, 1'b1, 4, 3, 0, "R4");
        drive(7*512, 1'b1, 4, 3, 0, "R4");
        // R5: just below start
        drive(4*512 - 1, 1'b1, 4, 3, 0, "R5");
        // R6: clip, no wrap
        drive(0, 1'b1, 14, 5, 3, "R6");
        drive(1*512, 1'b1, 14, 5, 3, "R6");
        drive(15*512, 1'b1, 14, 5, 3, "R6");
        drive(14*512, 1'b1, 14, 5, 3, "R6");
        // R7: exempt block inside region, at edges, outside
        drive(6*512, 1'b1, 4, 5, 6, "R7");
        drive(4*512, 1'b1, 4, 5, 4, "R7");
        drive(8*512 + 3, 1'b1, 4, 5, 8, "R7");
        drive(7*512, 1'b1, 4, 5, 6, "R7");
        // R8: page burst crossing edge of block 2 (protected), then leaving it
        for (int a = 1020; a < 1030; a++) drive(a, 1'b1, 2, 1, 0, "R8");
        for (int a = 1530; a < 1540; a++) drive(a, 1'b1, 2, 1, 0, "R8");
        // R4, R6, R7: full sweep of start, count and block
        for (int st = 0; st < 16; st++)
            for (int cnt = 0; cnt < 16; cnt++)
                for (int b = 0; b < 16; b++)
                    drive(b*512 + ((st*7 + cnt) % 512), 1'b1, st, cnt, (st + 3) % 16, "R4");
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule